// File: doc/BRIEF.md
# Raster Display Timing Generator

This block derives every horizontal and vertical timing signal of a 320-pixel-wide raster screen from one master clock. A pixel enable fires once every four master clocks. A pixel counter walks the 384 pixel slots of a scanline, starting at the front of horizontal sync. A 9-bit line counter walks 264 scanlines. The line counter does not start at zero: it occupies the top 264 codes of its 9-bit range.

From the two counters the block decodes several outputs:
- a composite sync, whose polarity flips on vertical-sync lines;
- an active-display flag;
- a colour-blank request, which tells the colour stage downstream to emit the reference colour (entry 0 of palette 0);
- a blank-to-zero signal, which follows the vertical visibility of each line but only switches partway into the back porch.

A mode input selects the visible area. In the short mode only the 224 central lines are visible. In the tall mode the 16-line borders above and below are visible as well, giving 256 lines.

The line counter is also presented in the upper bits of a status word. After a synchronous reset, both counters restart from a fixed position, so the first sync edge always lands at the same distance from reset.

Top module: `rasterTiming`

## Requirements
- R1: `pixEn` is high for exactly one master clock in every four, and `hCount` changes only on the clock edge that ends a cycle in which `pixEn` is high.
- R2: `hCount` counts 0 to 383 and then wraps to 0. Pixel 0 is the first pixel of horizontal sync. Pixels 0–27 are sync, 28–55 are back porch, 56–375 are the horizontal active window, and 376–383 are front porch.
- R3: `lineCount` steps by one on the master clock edge that ends pixel 383 (so it changes together with `hCount` returning to 0). It runs from 0x0F8 to 0x1FF and then wraps to 0x0F8, giving 264 lines per frame.
- R4: The line regions are: 0x0F8–0x0FF vertical sync, 0x100–0x10F top border, 0x110–0x1EF centre, 0x1F0–0x1FF bottom border. On lines 0x100–0x1FF, `syncOut` is 1 for pixels 0–27 and 0 otherwise. On the vertical-sync lines 0x0F8–0x0FF, it is the inverse.
- R5: With `tallMode` = 0, `activeDisp` is 1 exactly when the line is in 0x110–0x1EF and the pixel is in 56–375.
- R6: With `tallMode` = 1, `activeDisp` is 1 exactly when the line is in 0x100–0x1FF and the pixel is in 56–375.
- R7: `colorBlank` is 1 exactly when `activeDisp` is 0. This requests the reference colour, entry 0 of palette 0.
- R8: `blankZero` is a register that can change only on the edge that begins pixel 14 of a line. There it loads 1 if the current line is not visible in the mode sampled on that edge, and 0 if it is. It is 1 after reset.
- R9: A synchronous reset places the raster on line 0x0F8 at master-clock position 137 of 1536 (pixel 34, second clock of that pixel). The first falling edge of `syncOut` therefore comes 1399 clocks after the reset state, and sync then repeats with a period of 1536 clocks.
- R10: `statusWord[15:7]` carries `lineCount`, and `statusWord[6:0]` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| tallMode | input | 1 | 1 selects the 256-line visible area, 0 the 224-line area |
| pixEn | output | 1 | Pixel-clock enable, one master clock in four |
| hCount | output | 9 | Pixel position in the scanline, 0 at start of horizontal sync |
| lineCount | output | 9 | Scanline number, 0x0F8 to 0x1FF |
| syncOut | output | 1 | Composite sync, polarity inverted on vertical-sync lines |
| activeDisp | output | 1 | Pixel lies in the visible area of the selected mode |
| colorBlank | output | 1 | Request to output the reference colour |
| blankZero | output | 1 | Force video to zero level, switched at pixel 14 |
| statusWord | output | 16 | Status word with the line counter in bits 15:7 |

## Verification
The generator runs free from reset with `tallMode` toggled at random moments. Every cycle is compared against a model that computes position from the clock count alone. This separates a wrong counter period from a wrong region decode.

Mode toggles that fall between pixel 0 and pixel 14 of a line show whether `blankZero` samples the mode only at its switch point, while `activeDisp` follows the mode at once.

A second instance, with short scanlines, covers several whole frames in the time budget. It exercises the bottom border, the 0x1FF to 0x0F8 wrap and the vertical-sync polarity flip on both of its edges.

Reset is applied twice. Counting clocks to the first falling sync edge checks the start offset independently of the per-cycle compare.

// File: rtl/rasterPkg.sv
`timescale 1ns/1ps
package rasterPkg;

  // strobes from the horizontal control to the raster datapath
  typedef struct packed {
    logic pixEn;       // last master clock of a pixel
    logic lineEnd;     // pixel counter sits on the final pixel of the line
    logic blankLatch;  // pixel counter sits on the pixel before the blank switch
  } rasterStrobeT;

  typedef enum logic [1:0] {
    RG_VSYNC  = 2'd0,
    RG_BORDER = 2'd1,
    RG_CENTRE = 2'd2
  } lineRegionT;

endpackage

// File: rtl/rasterCtrl.sv
`timescale 1ns/1ps
module rasterCtrl
  import rasterPkg::*;
#(
  parameter int CLK_PER_PX = 4,
  parameter int H_TOTAL    = 384,
  parameter int BLANK_PX   = 14,
  parameter int RST_MCLK   = 137,
  parameter int HCNT_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  output rasterStrobeT      strobe,
  output logic [HCNT_W-1:0] hCount
);

  localparam int RST_PIX = (RST_MCLK / CLK_PER_PX) % H_TOTAL;
  localparam logic [HCNT_W-1:0] PIX_LAST  = HCNT_W'(H_TOTAL - 1);
  localparam logic [HCNT_W-1:0] PIX_PRE   = HCNT_W'(BLANK_PX - 1);
  localparam logic [HCNT_W-1:0] PIX_RESET = HCNT_W'(RST_PIX);

  logic              pixTick;
  logic [HCNT_W-1:0] pixPos;

  generate
    if (CLK_PER_PX == 1) begin : gNoDivide
      assign pixTick = 1'b1;
    end else begin : gDivide
      localparam int PH_W = $clog2(CLK_PER_PX);
      localparam logic [PH_W-1:0] PH_LAST  = PH_W'(CLK_PER_PX - 1);
      localparam logic [PH_W-1:0] PH_RESET = PH_W'(RST_MCLK % CLK_PER_PX);
      logic [PH_W-1:0] phase;

      always_ff @(posedge clk) begin
        if (rst)                 phase <= PH_RESET;
        else if (phase == PH_LAST) phase <= '0;
        else                     phase <= phase + PH_W'(1);
      end

      assign pixTick = (phase == PH_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pixPos <= PIX_RESET;
    end else if (pixTick) begin
      if (pixPos == PIX_LAST) pixPos <= '0;
      else                    pixPos <= pixPos + HCNT_W'(1);
    end
  end

  assign strobe.pixEn      = pixTick;
  assign strobe.lineEnd    = (pixPos == PIX_LAST);
  assign strobe.blankLatch = (pixPos == PIX_PRE);
  assign hCount            = pixPos;

endmodule

// File: rtl/rasterPath.sv
`timescale 1ns/1ps
module rasterPath
  import rasterPkg::*;
#(
  parameter int H_SYNC_PX = 28,
  parameter int H_BACK_PX = 28,
  parameter int H_ACT_PX  = 320,
  parameter int V_SYNC_LN = 8,
  parameter int V_TOP_LN  = 16,
  parameter int V_ACT_LN  = 224,
  parameter int V_BOT_LN  = 16,
  parameter int HCNT_W    = 9,
  parameter int LINE_W    = 9,
  parameter int STATUS_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tallMode,
  input  rasterStrobeT        strobe,
  input  logic [HCNT_W-1:0]   hCount,
  output logic [LINE_W-1:0]   lineCount,
  output logic                syncOut,
  output logic                activeDisp,
  output logic                colorBlank,
  output logic                blankZero,
  output logic [STATUS_W-1:0] statusWord
);

  localparam int V_TOTAL  = V_SYNC_LN + V_TOP_LN + V_ACT_LN + V_BOT_LN;
  localparam int FIRST_I  = (1 << LINE_W) - V_TOTAL;
  localparam int TOP_I    = FIRST_I + V_SYNC_LN;
  localparam int CENTRE_I = TOP_I + V_TOP_LN;
  localparam int BOT_I    = CENTRE_I + V_ACT_LN;

  localparam logic [LINE_W-1:0] LN_FIRST  = LINE_W'(FIRST_I);
  localparam logic [LINE_W-1:0] LN_LAST   = {LINE_W{1'b1}};
  localparam logic [LINE_W-1:0] LN_TOP    = LINE_W'(TOP_I);
  localparam logic [LINE_W-1:0] LN_CENTRE = LINE_W'(CENTRE_I);
  localparam logic [LINE_W-1:0] LN_BOT    = LINE_W'(BOT_I);

  localparam logic [HCNT_W-1:0] PX_SYNC_END = HCNT_W'(H_SYNC_PX);
  localparam logic [HCNT_W-1:0] PX_ACT_BEG  = HCNT_W'(H_SYNC_PX + H_BACK_PX);
  localparam logic [HCNT_W-1:0] PX_ACT_END  = HCNT_W'(H_SYNC_PX + H_BACK_PX + H_ACT_PX);

  logic [LINE_W-1:0] lineReg;
  logic              blankReg;
  lineRegionT        region;
  logic              lineVisible;
  logic              hSyncZone;
  logic              hActZone;

  // line counter over the offset range, wrapping at all-ones
  always_ff @(posedge clk) begin
    if (rst) begin
      lineReg <= LN_FIRST;
    end else if (strobe.pixEn && strobe.lineEnd) begin
      if (lineReg == LN_LAST) lineReg <= LN_FIRST;
      else                    lineReg <= lineReg + LINE_W'(1);
    end
  end

  always_comb begin
    if (lineReg < LN_TOP)                            region = RG_VSYNC;
    else if (lineReg < LN_CENTRE || lineReg >= LN_BOT) region = RG_BORDER;
    else                                             region = RG_CENTRE;
  end

  assign lineVisible = (region == RG_CENTRE) || (tallMode && region == RG_BORDER);
  assign hSyncZone   = (hCount < PX_SYNC_END);
  assign hActZone    = (hCount >= PX_ACT_BEG) && (hCount < PX_ACT_END);

  // blank-to-zero follows line visibility, switched part way into the back porch
  always_ff @(posedge clk) begin
    if (rst)                                   blankReg <= 1'b1;
    else if (strobe.pixEn && strobe.blankLatch) blankReg <= ~lineVisible;
  end

  assign lineCount  = lineReg;
  assign syncOut    = hSyncZone ^ (region == RG_VSYNC);
  assign activeDisp = lineVisible && hActZone;
  assign colorBlank = ~activeDisp;
  assign blankZero  = blankReg;

  generate
    if (STATUS_W > LINE_W) begin : gPadStatus
      assign statusWord = {lineReg, {(STATUS_W - LINE_W){1'b0}}};
    end else begin : gBareStatus
      assign statusWord = lineReg[LINE_W-1 -: STATUS_W];
    end
  endgenerate

endmodule

// File: rtl/rasterTiming.sv
`timescale 1ns/1ps
module rasterTiming
  import rasterPkg::*;
#(
  parameter int CLK_PER_PX = 4,
  parameter int H_SYNC_PX  = 28,
  parameter int H_BACK_PX  = 28,
  parameter int H_ACT_PX   = 320,
  parameter int H_FRONT_PX = 8,
  parameter int BLANK_PX   = 14,
  parameter int V_SYNC_LN  = 8,
  parameter int V_TOP_LN   = 16,
  parameter int V_ACT_LN   = 224,
  parameter int V_BOT_LN   = 16,
  parameter int RST_MCLK   = 137,
  parameter int HCNT_W     = 9,
  parameter int LINE_W     = 9,
  parameter int STATUS_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tallMode,
  output logic                pixEn,
  output logic [HCNT_W-1:0]   hCount,
  output logic [LINE_W-1:0]   lineCount,
  output logic                syncOut,
  output logic                activeDisp,
  output logic                colorBlank,
  output logic                blankZero,
  output logic [STATUS_W-1:0] statusWord
);

  localparam int H_TOTAL = H_SYNC_PX + H_BACK_PX + H_ACT_PX + H_FRONT_PX;

  rasterStrobeT strobe;

  rasterCtrl #(
    .CLK_PER_PX(CLK_PER_PX),
    .H_TOTAL   (H_TOTAL),
    .BLANK_PX  (BLANK_PX),
    .RST_MCLK  (RST_MCLK),
    .HCNT_W    (HCNT_W)
  ) uCtrl (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .hCount(hCount)
  );

  rasterPath #(
    .H_SYNC_PX(H_SYNC_PX),
    .H_BACK_PX(H_BACK_PX),
    .H_ACT_PX (H_ACT_PX),
    .V_SYNC_LN(V_SYNC_LN),
    .V_TOP_LN (V_TOP_LN),
    .V_ACT_LN (V_ACT_LN),
    .V_BOT_LN (V_BOT_LN),
    .HCNT_W   (HCNT_W),
    .LINE_W   (LINE_W),
    .STATUS_W (STATUS_W)
  ) uPath (
    .clk       (clk),
    .rst       (rst),
    .tallMode  (tallMode),
    .strobe    (strobe),
    .hCount    (hCount),
    .lineCount (lineCount),
    .syncOut   (syncOut),
    .activeDisp(activeDisp),
    .colorBlank(colorBlank),
    .blankZero (blankZero),
    .statusWord(statusWord)
  );

  assign pixEn = strobe.pixEn;

endmodule

// File: rtl/rasterTimingChk.sv
`timescale 1ns/1ps
module rasterTimingChk #(
  parameter int HCNT_W   = 9,
  parameter int LINE_W   = 9,
  parameter int BLANK_PX = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              pixEn,
  input logic [HCNT_W-1:0] hCount,
  input logic [LINE_W-1:0] lineCount,
  input logic              syncOut,
  input logic              blankZero
);

  AST_PIXEN_SPACED: assert property (@(posedge clk) disable iff (rst)
    pixEn |=> !pixEn); // R1

  AST_HCOUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> $stable(hCount)); // R1

  AST_LINE_AT_PIXEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$stable(lineCount) |-> (hCount == '0)); // R3

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!$stable(lineCount) && $past(lineCount) == {LINE_W{1'b1}}) |-> (lineCount == LINE_W'(9'h0F8))); // R3

  AST_SYNC_RISE_NORMAL: assert property (@(posedge clk) disable iff (rst)
    ($rose(syncOut) && lineCount >= LINE_W'(9'h100)) |-> (hCount == '0)); // R4

  AST_BLANK_SWITCH_POINT: assert property (@(posedge clk) disable iff (rst)
    !$stable(blankZero) |-> (hCount == HCNT_W'(BLANK_PX))); // R8

endmodule

bind rasterTiming rasterTimingChk uChk (
  .clk      (clk),
  .rst      (rst),
  .pixEn    (pixEn),
  .hCount   (hCount),
  .lineCount(lineCount),
  .syncOut  (syncOut),
  .blankZero(blankZero)
);

// File: tb/rasterTiming_test.sv
`timescale 1ns/1ps
module rasterTiming_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic tallMode = 1'b0;

  logic       peA, syA, acA, cbA, bzA;
  logic [8:0] hcA, lcA;
  logic [15:0] stA;
  logic       peB, syB, acB, cbB, bzB;
  logic [8:0] hcB, lcB;
  logic [15:0] stB;

  rasterTiming uut (
    .clk(clk), .rst(rst), .tallMode(tallMode), .pixEn(peA), .hCount(hcA),
    .lineCount(lcA), .syncOut(syA), .activeDisp(acA), .colorBlank(cbA),
    .blankZero(bzA), .statusWord(stA)
  );

  // short scanlines so whole frames fit in the run
  rasterTiming #(
    .CLK_PER_PX(2), .H_SYNC_PX(8), .H_BACK_PX(12), .H_ACT_PX(16), .H_FRONT_PX(4),
    .RST_MCLK(37)
  ) uut2 (
    .clk(clk), .rst(rst), .tallMode(tallMode), .pixEn(peB), .hCount(hcB),
    .lineCount(lcB), .syncOut(syB), .activeDisp(acB), .colorBlank(cbB),
    .blankZero(bzB), .statusWord(stB)
  );

  int     tests = 0;
  int     fails = 0;
  longint k = 0;
  bit     expBlankA = 1'b1;
  bit     expBlankB = 1'b1;
  bit     done = 1'b0;
  bit     prevSync = 1'b1;
  longint firstFall = -1;
  int unsigned seedDiscard;

  task automatic checkVal(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (k=%0d)", req, what, act, exp, k);
    end
  endtask

  function automatic bit lineVisible(input int line, input bit tall);
    if (tall) return (line >= 'h100);
    return (line >= 'h110 && line < 'h1F0);
  endfunction

  task automatic checkInst(input string tag, input int cpp, input int hs, input int hb,
                           input int ha, input int hf, input int rstOff,
                           input logic pe, input logic [8:0] hc, input logic [8:0] lc,
                           input logic sy, input logic ac, input logic cb, input logic bz,
                           input logic [15:0] st, inout bit expBlank);
    longint lineClk, frame, a, p;
    int     h, line;
    bit     vis, hAct, expAct;
    lineClk = longint'(hs + hb + ha + hf) * cpp;
    frame   = lineClk * 264;
    a       = (rstOff + k) % frame;
    p       = a % lineClk;
    h       = int'(p / cpp);
    line    = 'h0F8 + int'(a / lineClk);
    vis     = lineVisible(line, tallMode);
    if (p == 14 * cpp) expBlank = !vis;
    hAct    = (h >= hs + hb) && (h < hs + hb + ha);
    expAct  = vis && hAct;
    checkVal("R1", {tag, " pixEn"}, pe, (p % cpp) == cpp - 1);
    checkVal((k == 0) ? "R9" : "R2", {tag, " hCount"}, hc, h);
    checkVal((k == 0) ? "R9" : "R3", {tag, " lineCount"}, lc, line);
    checkVal("R4", {tag, " syncOut"}, sy, (h < hs) ^ (line < 'h100));
    checkVal(tallMode ? "R6" : "R5", {tag, " activeDisp"}, ac, expAct);
    checkVal("R7", {tag, " colorBlank"}, cb, !expAct);
    checkVal("R8", {tag, " blankZero"}, bz, expBlank);
    checkVal("R10", {tag, " statusWord"}, st, longint'(line) << 7);
  endtask

  task automatic checkBoth();
    checkInst("main", 4, 28, 28, 320, 8, 137, peA, hcA, lcA, syA, acA, cbA, bzA, stA, expBlankA);
    checkInst("short", 2, 8, 12, 16, 4, 37, peB, hcB, lcB, syB, acB, cbB, bzB, stB, expBlankB);
  endtask

  task automatic applyReset(input int n);
    rst = 1'b1;
    repeat (n) begin
      @(posedge clk); #1;
      k = 0;
      expBlankA = 1'b1;
      expBlankB = 1'b1;
      checkBoth();  // R9 reset position
      @(negedge clk);
    end
    rst = 1'b0;
    prevSync  = syA;
    firstFall = -1;
  endtask

  task automatic runCycles(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      k++;
      checkBoth();
      if (firstFall < 0 && prevSync && !syA) firstFall = k;
      prevSync = syA;
      @(negedge clk);
      if ($urandom_range(0, 1999) == 0) tallMode = ~tallMode;
    end
  endtask

  initial begin
    seedDiscard = $urandom(32'h5EED1234);
    applyReset(3);
    runCycles(1500);
    checkVal("R9", "main first falling sync", firstFall, 1399);
    runCycles(58000);
    // directed: tall mode across the second reset and top border
    tallMode = 1'b1;
    applyReset(2);
    runCycles(1500);
    checkVal("R9", "main first falling sync after re-reset", firstFall, 1399);
    runCycles(71500);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1950000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule